// File: doc/BRIEF.md
# Clock Period Jitter Meter

This block measures the period of an incoming clock in ticks of a faster sampling clock and keeps jitter statistics over a run. Each measured period yields two signed figures. The first is the offset from a programmed ideal period, called peak jitter. The second is the change from the period just before it, called cycle-to-cycle jitter. Cycle-to-cycle jitter is the figure that erodes setup and hold margin, so it is always collected.

Over a programmed number of periods the block keeps the largest magnitude of each jitter figure, the last values seen, the period count and a running period sum. The sum divided by the count gives the mean period. Software starts a run with a one-cycle start pulse and polls a done flag. It then reads the results through a small address-indexed read port. A controller with four named states runs each measurement. IDLE waits for a start. ARM waits for the first rising edge, which opens the first period. MEASURE collects one sample per rising edge. DONE freezes the results.

The transitions are as follows:
- start moves any state to ARM.
- In ARM, a rising edge moves to MEASURE, and a saturated counter moves to DONE.
- In MEASURE, the sample that reaches the target moves to DONE, and a saturated counter also moves to DONE.

Top module: `jitter_meter`

## Requirements
- R1: After reset, done and timeout are 0 and all eight read addresses return 0. Read addresses:
  - 0: status, with bit0 = done and bit1 = timeout.
  - 1: last period.
  - 2: largest |peak jitter|.
  - 3: largest |cycle-to-cycle jitter|.
  - 4: period sum.
  - 5: period count.
  - 6: last peak jitter, sign-extended.
  - 7: last cycle-to-cycle jitter, sign-extended.
- R2: A period is the number of sampling cycles between two consecutive rising edges of meas_clk. Address 1 returns the most recent period taken in the run.
- R3: Peak jitter of a period is the period minus ideal_period, in two's complement. Address 6 holds the last value and address 2 holds the largest magnitude seen in the run.
- R4: Cycle-to-cycle jitter is the period minus the previous period of the same run. The first period of a run yields no such sample. Address 7 holds the last value (0 if none) and address 3 holds the largest magnitude.
- R5: Address 4 holds the sum and address 5 the count of the periods taken in the run.
- R6: done rises once sample_target periods have been taken (a target of 0 acts as 1). It stays high until the next start, and later edges change no result.
- R7: A start pulse in any state clears every result, done and timeout. The first rising edge after start only opens a period.
- R8: The period counter saturates at 2^CNT_W-1. If it saturates in ARM or MEASURE with no edge, timeout and done both go to 1 and the results gathered so far are kept.
- R9: meas_clk passes through a two-flop synchronizer. Any period of at least 2 sampling cycles, with high and low phases each of at least 1 cycle, is measured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_clk | input | 1 | Clock under measurement, asynchronous |
| start | input | 1 | One-cycle pulse that clears results and arms a run |
| ideal_period | input | CNT_W | Ideal period in sampling cycles |
| sample_target | input | N_W | Number of periods per run |
| rd_addr | input | 3 | Result register select |
| rd_data | output | RD_W | Selected result, zero- or sign-extended |
| done | output | 1 | Run complete |
| timeout | output | 1 | Run ended by counter saturation |

## Verification
The hardest cases to reach from the ports are the saturation exits. One is reached with no edge at all, leaving the block stuck in ARM. The other is reached after a few periods, leaving partial statistics that must survive. The bench uses a small counter width so that both cases fit in a few hundred cycles. It holds meas_clk low after zero and after two rising periods, then checks the kept sum and count. A restart during MEASURE with pending history is also forced, to show that the cycle-to-cycle chain starts afresh. Sweeps of constant, alternating and ramped period patterns, including the 2-cycle minimum, cover the arithmetic. Extra edges are driven after each run completes.

// File: rtl/jm_pkg.sv
`timescale 1ns/1ps
package jm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARM     = 2'd1,
        ST_MEASURE = 2'd2,
        ST_DONE    = 2'd3
    } jm_state_e;

    localparam logic [2:0] A_STATUS   = 3'd0;
    localparam logic [2:0] A_PERIOD   = 3'd1;
    localparam logic [2:0] A_MAX_PK   = 3'd2;
    localparam logic [2:0] A_MAX_C2C  = 3'd3;
    localparam logic [2:0] A_SUM      = 3'd4;
    localparam logic [2:0] A_COUNT    = 3'd5;
    localparam logic [2:0] A_LAST_PK  = 3'd6;
    localparam logic [2:0] A_LAST_C2C = 3'd7;
endpackage

// File: rtl/jm_edge_sync.sv
`timescale 1ns/1ps
module jm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/jm_period_ctr.sv
`timescale 1ns/1ps
module jm_period_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rise,
    output logic [CNT_W-1:0] period,
    output logic             stall
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clear)           cnt_q <= '0;
        else if (rise)            cnt_q <= CNT_W'(1);
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign period = cnt_q;
    assign stall  = (cnt_q == CNT_MAX) && !rise;
endmodule

// File: rtl/jm_stats.sv
`timescale 1ns/1ps
module jm_stats #(
    parameter int CNT_W = 16,
    parameter int N_W   = 8,
    parameter int SUM_W = CNT_W + N_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    sample,
    input  logic [CNT_W-1:0]        period,
    input  logic [CNT_W-1:0]        ideal,
    output logic [CNT_W-1:0]        last_period,
    output logic signed [CNT_W:0]   last_pk,
    output logic signed [CNT_W:0]   last_c2c,
    output logic [CNT_W-1:0]        max_pk,
    output logic [CNT_W-1:0]        max_c2c,
    output logic [SUM_W-1:0]        sum,
    output logic [N_W-1:0]          count
);
    logic signed [CNT_W:0] pk, c2c;
    logic [CNT_W-1:0]      pk_mag, c2c_mag;
    logic                  have_prev_q;

    function automatic logic [CNT_W-1:0] magnitude(input logic signed [CNT_W:0] v);
        logic [CNT_W:0] t;
        t = v[CNT_W] ? -v : v;
        return t[CNT_W-1:0];
    endfunction

    assign pk      = $signed({1'b0, period}) - $signed({1'b0, ideal});
    assign c2c     = $signed({1'b0, period}) - $signed({1'b0, last_period});
    assign pk_mag  = magnitude(pk);
    assign c2c_mag = magnitude(c2c);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_period <= '0; last_pk <= '0; last_c2c <= '0;
            max_pk <= '0; max_c2c <= '0; sum <= '0; count <= '0;
            have_prev_q <= 1'b0;
        end else if (clear) begin
            last_period <= '0; last_pk <= '0; last_c2c <= '0;
            max_pk <= '0; max_c2c <= '0; sum <= '0; count <= '0;
            have_prev_q <= 1'b0;
        end else if (sample) begin
            last_period <= period;
            last_pk     <= pk;
            count       <= count + 1'b1;
            sum         <= sum + SUM_W'(period);
            have_prev_q <= 1'b1;
            if (pk_mag > max_pk) max_pk <= pk_mag;
            if (have_prev_q) begin
                last_c2c <= c2c;
                if (c2c_mag > max_c2c) max_c2c <= c2c_mag;
            end
        end
    end
endmodule

// File: rtl/jitter_meter.sv
`timescale 1ns/1ps
module jitter_meter #(
    parameter int CNT_W = 16,
    parameter int N_W   = 8,
    parameter int RD_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_clk,
    input  logic             start,
    input  logic [CNT_W-1:0] ideal_period,
    input  logic [N_W-1:0]   sample_target,
    input  logic [2:0]       rd_addr,
    output logic [RD_W-1:0]  rd_data,
    output logic             done,
    output logic             timeout
);
    import jm_pkg::*;

    localparam int SUM_W = CNT_W + N_W;
    localparam int EXT_W = RD_W - CNT_W - 1;

    jm_state_e state_q, state_d;

    logic                  rise, stall, sample, last_sample, timeout_q;
    logic [CNT_W-1:0]      period, last_period, max_pk, max_c2c;
    logic signed [CNT_W:0] last_pk, last_c2c;
    logic [SUM_W-1:0]      sum;
    logic [N_W-1:0]        count;

    jm_edge_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(meas_clk), .rise(rise)
    );

    jm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clear(start), .rise(rise),
        .period(period), .stall(stall)
    );

    jm_stats #(.CNT_W(CNT_W), .N_W(N_W), .SUM_W(SUM_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .clear(start), .sample(sample),
        .period(period), .ideal(ideal_period),
        .last_period(last_period), .last_pk(last_pk), .last_c2c(last_c2c),
        .max_pk(max_pk), .max_c2c(max_c2c), .sum(sum), .count(count)
    );

    assign last_sample = ({1'b0, count} + 1'b1) >= {1'b0, sample_target};

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_ARM;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_ARM:     if (stall) state_d = ST_DONE;
                            else if (rise) state_d = ST_MEASURE;
                ST_MEASURE: if (stall) state_d = ST_DONE;
                            else if (rise && last_sample) state_d = ST_DONE;
                ST_DONE:    state_d = ST_DONE;
            endcase
        end
    end

    // state register and timeout flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            timeout_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start)
                timeout_q <= 1'b0;
            else if (stall && (state_q == ST_ARM || state_q == ST_MEASURE))
                timeout_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        sample  = (state_q == ST_MEASURE) && rise && !start;
        done    = (state_q == ST_DONE);
        timeout = timeout_q;
        unique case (rd_addr)
            A_STATUS:   rd_data = RD_W'({timeout_q, done});
            A_PERIOD:   rd_data = RD_W'(last_period);
            A_MAX_PK:   rd_data = RD_W'(max_pk);
            A_MAX_C2C:  rd_data = RD_W'(max_c2c);
            A_SUM:      rd_data = RD_W'(sum);
            A_COUNT:    rd_data = RD_W'(count);
            A_LAST_PK:  rd_data = {{EXT_W{last_pk[CNT_W]}}, last_pk};
            A_LAST_C2C: rd_data = {{EXT_W{last_c2c[CNT_W]}}, last_c2c};
        endcase
    end
endmodule

// File: rtl/jitter_meter_checker.sv
`timescale 1ns/1ps
module jitter_meter_checker #(
    parameter int CNT_W = 16,
    parameter int N_W   = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   done,
    input logic                   timeout,
    input logic [CNT_W-1:0]       max_pk,
    input logic [CNT_W-1:0]       max_c2c,
    input logic [CNT_W+N_W-1:0]   sum,
    input logic [N_W-1:0]         count
);
    assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_frozen_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(sum) && $stable(count) && $stable(max_pk)));

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !timeout && count == '0 && sum == '0 && max_c2c == '0));

    assert_max_pk_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (max_pk >= $past(max_pk)));

    assert_max_c2c_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (max_c2c >= $past(max_c2c)));

    assert_timeout_ends_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);
endmodule

bind jitter_meter jitter_meter_checker #(.CNT_W(CNT_W), .N_W(N_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .timeout(timeout),
    .max_pk(max_pk), .max_c2c(max_c2c), .sum(sum), .count(count)
);

// File: tb/jitter_meter_test.sv
`timescale 1ns/1ps
module jitter_meter_test;
    localparam int CNT_W = 8;
    localparam int N_W   = 4;
    localparam int RD_W  = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             meas_clk = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] ideal_period = '0;
    logic [N_W-1:0]   sample_target = '0;
    logic [2:0]       rd_addr = '0;
    logic [RD_W-1:0]  rd_data;
    logic             done, timeout;

    int checks = 0;
    int errors = 0;
    int per [0:15];

    always #4 clk = ~clk;

    jitter_meter #(.CNT_W(CNT_W), .N_W(N_W), .RD_W(RD_W)) uut (
        .clk(clk), .rst_n(rst_n), .meas_clk(meas_clk), .start(start),
        .ideal_period(ideal_period), .sample_target(sample_target),
        .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .timeout(timeout)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, $signed(act), $signed(exp));
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic do_start(input int ideal, input int target);
        @(negedge clk);
        ideal_period  = CNT_W'(ideal);
        sample_target = N_W'(target);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // first rise opens a period, then one rise per entry of per[]
    task automatic drive(input int n);
        @(negedge clk);
        meas_clk = 1'b1;
        for (int i = 0; i < n; i++) begin
            int h;
            h = per[i] / 2;
            repeat (h) @(negedge clk);
            meas_clk = 1'b0;
            repeat (per[i] - h) @(negedge clk);
            meas_clk = 1'b1;
        end
        repeat (2) @(negedge clk);
        meas_clk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_results(input int ideal, input int taken, input int status, input string tag);
        int s, mpk, mc, d, lp, lpk, lc;
        logic [31:0] v;
        s = 0; mpk = 0; mc = 0; lp = 0; lpk = 0; lc = 0;
        for (int i = 0; i < taken; i++) begin
            s += per[i];
            d = per[i] - ideal;
            if (d < 0) d = -d;
            if (d > mpk) mpk = d;
            if (i > 0) begin
                d = per[i] - per[i-1];
                lc = d;
                if (d < 0) d = -d;
                if (d > mc) mc = d;
            end
            lp = per[i];
            lpk = per[i] - ideal;
        end
        rd(3'd0, v); check({tag, " R6 R8 status"}, v, 32'(status));
        rd(3'd1, v); check({tag, " R2 R9 last period"}, v, 32'(lp));
        rd(3'd2, v); check({tag, " R3 max peak"}, v, 32'(mpk));
        rd(3'd3, v); check({tag, " R4 max c2c"}, v, 32'(mc));
        rd(3'd4, v); check({tag, " R5 sum"}, v, 32'(s));
        rd(3'd5, v); check({tag, " R5 count"}, v, 32'(taken));
        rd(3'd6, v); check({tag, " R3 last peak"}, v, 32'(lpk));
        rd(3'd7, v); check({tag, " R4 last c2c"}, v, 32'(lc));
    endtask

    task automatic run(input int ideal, input int target, input int ndrive, input string tag);
        int taken;
        taken = (target == 0) ? 1 : target;
        do_start(ideal, target);
        drive(ndrive);
        check({tag, " R6 done pin"}, 32'(done), 32'd1);
        expect_results(ideal, taken, 1, tag);
    endtask

    initial begin
        #(150000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, 32'd0);
        end
        check("R1 done pin", 32'(done), 32'd0);

        // constant periods, 2 is the minimum (R9)
        for (int p = 2; p <= 12; p++) begin
            for (int i = 0; i < 16; i++) per[i] = p;
            run(6, 5, 7, "const");
        end

        // alternating periods
        for (int b = 3; b <= 6; b++)
            for (int d = 1; d <= 3; d++) begin
                for (int i = 0; i < 16; i++) per[i] = (i % 2 == 0) ? b : b + d;
                run(b + 1, 6, 8, "alt");
            end

        // ramp
        for (int i = 0; i < 16; i++) per[i] = 2 + i;
        run(8, 12, 14, "ramp");

        // target 0 acts as 1
        for (int i = 0; i < 16; i++) per[i] = 9 - i % 3;
        run(5, 0, 3, "tgt0");

        // R7 restart mid-run
        for (int i = 0; i < 16; i++) per[i] = 3 + 2 * (i % 2);
        do_start(4, 10);
        drive(3);
        check("R7 not done before restart", 32'(done), 32'd0);
        do_start(7, 4);
        rd(3'd4, v); check("R7 sum cleared", v, 32'd0);
        rd(3'd5, v); check("R7 count cleared", v, 32'd0);
        rd(3'd3, v); check("R7 max c2c cleared", v, 32'd0);
        for (int i = 0; i < 16; i++) per[i] = 5 + (i == 2 ? 3 : 0);
        drive(5);
        expect_results(7, 4, 1, "restart");

        // R8 timeout with no edge at all
        do_start(5, 3);
        repeat (300) @(negedge clk);
        check("R8 timeout pin", 32'(timeout), 32'd1);
        rd(3'd0, v); check("R8 status idle input", v, 32'd3);
        rd(3'd5, v); check("R8 count idle input", v, 32'd0);

        // R8 timeout after two periods keeps partial results
        for (int i = 0; i < 16; i++) per[i] = 6 + i;
        do_start(6, 10);
        drive(2);
        repeat (300) @(negedge clk);
        expect_results(6, 2, 3, "partial");

        // R7 start clears timeout
        do_start(6, 2);
        check("R7 timeout cleared", 32'(timeout), 32'd0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule